// File: doc/BRIEF.md
# Alternate-Mode Launch and Bridge Prefix Detector

This block sits beside the byte-wide instruction fetch stream of a host processor front end. It watches every accepted byte for three patterns. The first is a two-byte launch opcode. The other two are three-byte bridge prefixes that look like ordinary host instructions. A privileged configuration register holds a mode-enable bit, and a feature-query port reports that the hidden instruction set is supported and whether it is currently enabled.

When the launch opcode arrives, the block checks the enable bit. If the bit is set, it asks the front end to redirect fetch to the value of the host accumulator register and enters alternate mode. If the bit is clear, it raises an invalid-opcode fault instead.

Once alternate mode is active, each bridge prefix is followed by a 32-bit alternate instruction. The block gathers that word from the next four bytes and hands it to the secondary core with a one-cycle valid pulse. Outside alternate mode, bridge prefixes are ordinary host bytes and nothing is captured.

Top module: `altmode_prefix_detector`

The matcher has seven states:

| State | Meaning |
|---|---|
| ST_IDLE | No partial match |
| ST_LNCH1 | Seen 0x0F |
| ST_BRA1 | Seen 0x8D |
| ST_BRA2 | Seen 0x8D 0x84 |
| ST_BRB1 | Seen 0x62 |
| ST_BRB2 | Seen 0x62 0x04 |
| ST_PAYLD | Collecting payload bytes |

Its transitions are:

- **Start.** From any matching state, a byte that does not continue the pattern goes back through the first-byte decision. A byte of 0x0F goes to ST_LNCH1, 0x8D to ST_BRA1, 0x62 to ST_BRB1, and any other byte to ST_IDLE.
- **Launch.** ST_LNCH1 with 0x3F completes the launch and returns to ST_IDLE.
- **Bridge.** ST_BRA1 with 0x84 goes to ST_BRA2, and ST_BRA2 with 0x00 completes a bridge. ST_BRB1 with 0x04 goes to ST_BRB2, and ST_BRB2 with 0x05 completes a bridge. A completed bridge enters ST_PAYLD in alternate mode and goes to ST_IDLE otherwise.
- **Payload.** ST_PAYLD stays put for four accepted bytes, then returns to ST_IDLE.
- **Gaps.** Cycles with no valid byte hold every state.

## Requirements
- R1: After synchronous reset the enable bit is 0 and alternate mode is off. A feature query with function 0xC0000001 returns 0x00000001: bit 0 = supported, bit 1 = enabled. redirect_vld, ill_fault, payload_vld and prot_fault are all 0.
- R2: Launch with the enable bit set: bytes 0x0F then 0x3F. One cycle after 0x3F is accepted, redirect_vld pulses for one cycle with redirect_addr equal to host_acc as sampled with 0x3F. alt_mode then reads 1.
- R3: The same launch with the enable bit clear pulses ill_fault for one cycle, gives no redirect, and leaves alt_mode at 0.
- R4: In alternate mode, bytes 0x8D 0x84 0x00 followed by four bytes produce one payload_vld pulse, one cycle after the fourth byte. payload_dat is little-endian: the first byte lands in bits 7:0.
- R5: Bytes 0x62 0x04 0x05 act as a bridge prefix exactly like R4.
- R6: A bridge prefix seen while alternate mode is off captures no payload.
- R7: When a partial match fails, the failing byte is re-examined as a first byte. So 0x0F 0x0F 0x3F launches, and 0x8D 0x8D 0x84 0x00 is a bridge.
- R8: A privileged write to index 0x1107 stores cfg_wdata in the register, and bit 0 is the enable bit. A write to any other index changes nothing. cfg_rdata returns the register when cfg_idx is 0x1107 and 0 otherwise.
- R9: A write with cfg_priv low leaves the register unchanged and pulses prot_fault for one cycle.
- R10: The feature word reports bit 1 equal to the enable bit for function 0xC0000001. Any other function returns 0.
- R11: Clearing the enable bit takes the block out of alternate mode by the following cycle.
- R12: Payload bytes are never matched, so 0x0F 0x3F inside a payload causes no launch.
- R13: Cycles with byte_vld low neither advance nor reset a partial match or a payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | Fetch byte valid |
| byte_dat | input | 8 | Fetch byte |
| host_acc | input | 32 | Host accumulator value, used as redirect target |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Write is privileged |
| cfg_idx | input | 16 | Configuration register index, for both read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| feat_func | input | 32 | Feature query function code |
| feat_word | output | 32 | Feature query result |
| prot_fault | output | 1 | Pulse on an unprivileged write |
| redirect_vld | output | 1 | Redirect request pulse |
| redirect_addr | output | 32 | Redirect target |
| ill_fault | output | 1 | Invalid-opcode pulse |
| alt_mode | output | 1 | Alternate mode active |
| payload_vld | output | 1 | Payload word valid pulse |
| payload_dat | output | 32 | Gathered alternate instruction |

## Verification
The bench targets the cases a careless matcher gets wrong. A matcher that simply drops back to idle on a mismatch would miss 0x0F 0x0F 0x3F and the doubled 0x8D bridge. A matcher that keeps decoding inside a payload would fire a false redirect on a 0x0F 0x3F embedded in the data. Gaps in byte_vld and a launch through a partial bridge (0x8D 0x84 0x0F 0x3F) probe state holding and rescan. On the configuration side, the bench checks that an unprivileged write leaves the register intact and that a disabled launch faults instead of redirecting.

// File: rtl/altmode_pkg.sv
package altmode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LNCH1,
        ST_BRA1,
        ST_BRA2,
        ST_BRB1,
        ST_BRB2,
        ST_PAYLD
    } match_st_e;

    localparam logic [7:0] LNCH_B0 = 8'h0F;
    localparam logic [7:0] LNCH_B1 = 8'h3F;
    localparam logic [7:0] BRA_B0  = 8'h8D;
    localparam logic [7:0] BRA_B1  = 8'h84;
    localparam logic [7:0] BRA_B2  = 8'h00;
    localparam logic [7:0] BRB_B0  = 8'h62;
    localparam logic [7:0] BRB_B1  = 8'h04;
    localparam logic [7:0] BRB_B2  = 8'h05;

    function automatic match_st_e first_state(input logic [7:0] b);
        if (b == LNCH_B0)     return ST_LNCH1;
        else if (b == BRA_B0) return ST_BRA1;
        else if (b == BRB_B0) return ST_BRB1;
        else                  return ST_IDLE;
    endfunction

endpackage

// File: rtl/altmode_cfg.sv
module altmode_cfg #(
    parameter int              IDX_W     = 16,
    parameter int              DW        = 32,
    parameter logic [15:0]     CFG_INDEX = 16'h1107,
    parameter logic [31:0]     FEAT_CODE = 32'hC000_0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             priv,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic [31:0]      func,
    output logic [DW-1:0]    rdata,
    output logic [31:0]      feat,
    output logic             mode_en,
    output logic             prot_fault
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(CFG_INDEX);

    logic [DW-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            prot_fault <= 1'b0;
        end else begin
            prot_fault <= wr && !priv;
            if (wr && priv && idx == MY_IDX)
                cfg_q <= wdata;
        end
    end

    assign mode_en = cfg_q[0];
    assign rdata   = (idx == MY_IDX) ? cfg_q : '0;
    assign feat    = (func == FEAT_CODE) ? {30'd0, mode_en, 1'b1} : 32'd0;
endmodule

// File: rtl/altmode_matcher.sv
module altmode_matcher
    import altmode_pkg::*;
#(
    parameter int PAY_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    input  logic [ADDR_W-1:0] host_acc,
    input  logic              mode_en,
    output logic              redirect_vld,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              ill_fault,
    output logic              alt_mode,
    output logic              payload_vld,
    output logic [PAY_W-1:0]  payload_dat
);
    localparam int             PAY_BYTES = PAY_W / 8;
    localparam int             CNT_W     = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAY_BYTES - 1);

    match_st_e        st, st_n;
    logic [CNT_W-1:0] cnt;
    logic [PAY_W-1:0] acc, acc_n;
    logic             launch_hit;
    logic             take_pay;

    // lane merge: the byte arriving now replaces the lane selected by cnt
    for (genvar i = 0; i < PAY_BYTES; i++) begin : g_lane
        assign acc_n[i*8 +: 8] = (cnt == CNT_W'(i)) ? byte_dat : acc[i*8 +: 8];
    end

    always_comb begin
        st_n       = st;
        launch_hit = 1'b0;
        take_pay   = 1'b0;
        if (byte_vld) begin
            unique case (st)
                ST_IDLE:  st_n = first_state(byte_dat);
                ST_LNCH1: begin
                    if (byte_dat == LNCH_B1) begin
                        launch_hit = 1'b1;
                        st_n       = ST_IDLE;
                    end else begin
                        st_n = first_state(byte_dat);
                    end
                end
                ST_BRA1:  st_n = (byte_dat == BRA_B1) ? ST_BRA2 : first_state(byte_dat);
                ST_BRA2:  begin
                    if (byte_dat == BRA_B2) st_n = alt_mode ? ST_PAYLD : ST_IDLE;
                    else                    st_n = first_state(byte_dat);
                end
                ST_BRB1:  st_n = (byte_dat == BRB_B1) ? ST_BRB2 : first_state(byte_dat);
                ST_BRB2:  begin
                    if (byte_dat == BRB_B2) st_n = alt_mode ? ST_PAYLD : ST_IDLE;
                    else                    st_n = first_state(byte_dat);
                end
                ST_PAYLD: begin
                    take_pay = 1'b1;
                    st_n     = (cnt == CNT_LAST) ? ST_IDLE : ST_PAYLD;
                end
                default:  st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt           <= '0;
            acc           <= '0;
            redirect_vld  <= 1'b0;
            redirect_addr <= '0;
            ill_fault     <= 1'b0;
            alt_mode      <= 1'b0;
            payload_vld   <= 1'b0;
            payload_dat   <= '0;
        end else begin
            redirect_vld <= 1'b0;
            ill_fault    <= 1'b0;
            payload_vld  <= 1'b0;
            if (!mode_en) alt_mode <= 1'b0;
            if (launch_hit) begin
                if (mode_en) begin
                    redirect_vld  <= 1'b1;
                    redirect_addr <= host_acc;
                    alt_mode      <= 1'b1;
                end else begin
                    ill_fault <= 1'b1;
                end
            end
            if (take_pay) begin
                acc <= acc_n;
                if (cnt == CNT_LAST) begin
                    cnt         <= '0;
                    payload_vld <= 1'b1;
                    payload_dat <= acc_n;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/altmode_prefix_detector.sv
module altmode_prefix_detector #(
    parameter int          IDX_W     = 16,
    parameter int          DW        = 32,
    parameter int          PAY_W     = 32,
    parameter int          ADDR_W    = 32,
    parameter logic [15:0] CFG_INDEX = 16'h1107,
    parameter logic [31:0] FEAT_CODE = 32'hC000_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    input  logic [ADDR_W-1:0] host_acc,
    input  logic              cfg_wr,
    input  logic              cfg_priv,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic [31:0]       feat_func,
    output logic [31:0]       feat_word,
    output logic              prot_fault,
    output logic              redirect_vld,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              ill_fault,
    output logic              alt_mode,
    output logic              payload_vld,
    output logic [PAY_W-1:0]  payload_dat
);
    logic mode_en;

    altmode_cfg #(
        .IDX_W(IDX_W), .DW(DW), .CFG_INDEX(CFG_INDEX), .FEAT_CODE(FEAT_CODE)
    ) cfg_i (
        .clk(clk), .rst(rst), .wr(cfg_wr), .priv(cfg_priv), .idx(cfg_idx),
        .wdata(cfg_wdata), .func(feat_func), .rdata(cfg_rdata), .feat(feat_word),
        .mode_en(mode_en), .prot_fault(prot_fault)
    );

    altmode_matcher #(.PAY_W(PAY_W), .ADDR_W(ADDR_W)) match_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .host_acc(host_acc), .mode_en(mode_en), .redirect_vld(redirect_vld),
        .redirect_addr(redirect_addr), .ill_fault(ill_fault), .alt_mode(alt_mode),
        .payload_vld(payload_vld), .payload_dat(payload_dat)
    );
endmodule

// File: rtl/altmode_chk.sv
module altmode_chk #(
    parameter logic [31:0] FEAT_CODE = 32'hC000_0001
) (
    input logic        clk,
    input logic        rst,
    input logic        mode_en,
    input logic        alt_mode,
    input logic        redirect_vld,
    input logic        ill_fault,
    input logic        payload_vld,
    input logic        prot_fault,
    input logic [31:0] feat_func,
    input logic [31:0] feat_word
);
    p_redirect_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        redirect_vld |-> ($past(mode_en) && alt_mode));

    p_fault_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        ill_fault |-> (!$past(mode_en) && !redirect_vld));

    p_payload_single_r4: assert property (@(posedge clk) disable iff (rst)
        payload_vld |=> !payload_vld);

    p_prot_keeps_cfg_r9: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> $stable(mode_en));

    p_feat_supported_r10: assert property (@(posedge clk) disable iff (rst)
        (feat_func == FEAT_CODE) |-> feat_word[0]);

    p_mode_drop_r11: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> !alt_mode);
endmodule

bind altmode_prefix_detector altmode_chk #(.FEAT_CODE(FEAT_CODE)) chk_i (
    .clk(clk), .rst(rst), .mode_en(mode_en), .alt_mode(alt_mode),
    .redirect_vld(redirect_vld), .ill_fault(ill_fault), .payload_vld(payload_vld),
    .prot_fault(prot_fault), .feat_func(feat_func), .feat_word(feat_word)
);

// File: tb/altmode_prefix_detector_tb_top.sv
module altmode_prefix_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic [31:0] host_acc = '0;
    logic        cfg_wr = 1'b0, cfg_priv = 1'b0;
    logic [15:0] cfg_idx = 16'h1107;
    logic [31:0] cfg_wdata = '0, cfg_rdata, feat_func = 32'hC000_0001, feat_word;
    logic        prot_fault, redirect_vld, ill_fault, alt_mode, payload_vld;
    logic [31:0] redirect_addr, payload_dat;

    int n_chk = 0, n_bad = 0;
    int mon_red = 0, mon_flt = 0, mon_pay = 0;
    logic [31:0] mon_last_pay = '0, mon_last_addr = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    altmode_prefix_detector dut_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .host_acc(host_acc), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .feat_func(feat_func),
        .feat_word(feat_word), .prot_fault(prot_fault), .redirect_vld(redirect_vld),
        .redirect_addr(redirect_addr), .ill_fault(ill_fault), .alt_mode(alt_mode),
        .payload_vld(payload_vld), .payload_dat(payload_dat)
    );

    always @(negedge clk) begin
        if (redirect_vld) begin mon_red++; mon_last_addr = redirect_addr; end
        if (ill_fault)    mon_flt++;
        if (payload_vld)  begin mon_pay++; mon_last_pay = payload_dat; end
    end

    // table: first byte in the top byte of each row
    localparam logic [63:0] T_SEQ [7] = '{
        64'h8D84_0011_2233_4400, 64'h6204_05AA_BBCC_DD00, 64'h8D8D_8400_0102_0304,
        64'h0F0F_3F00_0000_0000, 64'h6262_0405_0F3F_0080, 64'h8D84_010F_3F00_0000,
        64'h8D84_0F3F_0000_0000 };
    localparam int          T_LEN [7] = '{7, 7, 8, 3, 8, 5, 4};
    localparam int          T_RED [7] = '{0, 0, 0, 1, 0, 1, 1};
    localparam int          T_PV  [7] = '{1, 1, 1, 0, 1, 0, 0};
    localparam logic [31:0] T_PAY [7] = '{
        32'h4433_2211, 32'hDDCC_BBAA, 32'h0403_0201, 32'h0,
        32'h8000_3F0F, 32'h0, 32'h0 };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_dat = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic cfg_write(input logic [15:0] idx, input logic [31:0] d, input logic p);
        cfg_wr = 1'b1; cfg_priv = p; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_priv = 1'b0; cfg_idx = 16'h1107;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int p_red, p_flt, p_pay;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg", cfg_rdata, 32'h0);
        check("R1 feat", feat_word, 32'h1);
        check("R1 mode", {31'd0, alt_mode}, 32'd0);
        check("R1 pulses", {28'd0, redirect_vld, ill_fault, payload_vld, prot_fault}, 32'd0);

        // R6: bridge while disabled, no payload
        p_pay = mon_pay;
        put(8'h8D); put(8'h84); put(8'h00);
        put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        idle(2);
        check("R6 no payload", mon_pay - p_pay, 0);

        // R3: launch while disabled
        host_acc = 32'h1234_5678;
        put(8'h0F); put(8'h3F);
        check("R3 fault", {31'd0, ill_fault}, 32'd1);
        check("R3 redirect", {31'd0, redirect_vld}, 32'd0);
        @(negedge clk);
        check("R3 fault pulse", {31'd0, ill_fault}, 32'd0);
        check("R3 mode", {31'd0, alt_mode}, 32'd0);

        // R9: unprivileged write
        cfg_write(16'h1107, 32'h1, 1'b0);
        check("R9 prot", {31'd0, prot_fault}, 32'd1);
        check("R9 unchanged", cfg_rdata, 32'h0);
        @(negedge clk);
        check("R9 pulse", {31'd0, prot_fault}, 32'd0);

        // R8: other index ignored, then real write
        cfg_write(16'h1108, 32'h1, 1'b1);
        check("R8 other idx", cfg_rdata, 32'h0);
        cfg_idx = 16'h1108;
        #0 check("R8 read other", cfg_rdata, 32'h0);
        cfg_idx = 16'h1107;
        cfg_write(16'h1107, 32'h0000_00A1, 1'b1);
        check("R8 write", cfg_rdata, 32'h0000_00A1);

        // R10 feature word
        check("R10 enabled", feat_word, 32'h3);
        feat_func = 32'hC000_0000;
        #1 check("R10 other func", feat_word, 32'h0);
        feat_func = 32'hC000_0001;

        // R9 again while enabled: cannot clear
        cfg_write(16'h1107, 32'h0, 1'b0);
        check("R9 keep enabled", cfg_rdata, 32'h0000_00A1);

        // R2 launch with timing
        host_acc = 32'hDEAD_BEEF;
        put(8'h0F); put(8'h3F);
        host_acc = 32'h0;
        check("R2 redirect", {31'd0, redirect_vld}, 32'd1);
        check("R2 addr", redirect_addr, 32'hDEAD_BEEF);
        check("R2 mode", {31'd0, alt_mode}, 32'd1);
        @(negedge clk);
        check("R2 pulse", {31'd0, redirect_vld}, 32'd0);

        // R4 exact timing
        put(8'h8D); put(8'h84); put(8'h00);
        put(8'hA0); put(8'hB1); put(8'hC2);
        check("R4 early", {31'd0, payload_vld}, 32'd0);
        put(8'hD3);
        check("R4 vld", {31'd0, payload_vld}, 32'd1);
        check("R4 data", payload_dat, 32'hD3C2_B1A0);
        @(negedge clk);
        check("R4 pulse", {31'd0, payload_vld}, 32'd0);

        // R13 gaps inside prefix and payload
        p_pay = mon_pay;
        put(8'h62); idle(3); put(8'h04); idle(2); put(8'h05);
        put(8'h01); idle(2); put(8'h02); put(8'h03); idle(1); put(8'h04);
        idle(2);
        check("R13 count", mon_pay - p_pay, 1);
        check("R13 data", mon_last_pay, 32'h0403_0201);

        // table walk: R5, R7, R12 and more R4
        for (int i = 0; i < 7; i++) begin
            p_red = mon_red; p_flt = mon_flt; p_pay = mon_pay;
            host_acc = 32'h1000_0000 + i;
            for (int j = 0; j < T_LEN[i]; j++) put(T_SEQ[i][63 - 8*j -: 8]);
            idle(2);
            check($sformatf("R7 R12 row%0d redirects", i), mon_red - p_red, T_RED[i]);
            check($sformatf("R5 R4 row%0d payloads", i), mon_pay - p_pay, T_PV[i]);
            check($sformatf("R3 row%0d faults", i), mon_flt - p_flt, 0);
            if (T_PV[i] != 0) check($sformatf("R4 row%0d data", i), mon_last_pay, T_PAY[i]);
            if (T_RED[i] != 0) check($sformatf("R2 row%0d addr", i), mon_last_addr, 32'h1000_0000 + i);
        end

        // R11: clearing enable leaves alternate mode
        cfg_write(16'h1107, 32'h0, 1'b1);
        @(negedge clk);
        check("R11 mode off", {31'd0, alt_mode}, 32'd0);
        check("R10 disabled", feat_word, 32'h1);
        p_pay = mon_pay; p_flt = mon_flt;
        put(8'h8D); put(8'h84); put(8'h00);
        put(8'h55); put(8'h66); put(8'h77); put(8'h88);
        put(8'h0F); put(8'h3F);
        idle(2);
        check("R11 R6 no payload", mon_pay - p_pay, 0);
        check("R11 R3 fault", mon_flt - p_flt, 1);

        // R1 reset mid-state clears enable
        cfg_write(16'h1107, 32'h1, 1'b1);
        put(8'h0F);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        check("R1 reset enable", cfg_rdata, 32'h0);
        p_red = mon_red; p_flt = mon_flt;
        put(8'h3F); idle(2);
        check("R1 partial cleared", mon_red + mon_flt - p_red - p_flt, 0);

        finish_run();
    end
endmodule